// File: doc/BRIEF.md
# Shared-Function Message Router

This block sits between a group of execution threads and the shared function units that serve them. Each thread offers one request at a time. The request holds a 4-bit function ID, an operation code that only the chosen function interprets, an operand payload and the index of the register that should receive the reply. The router decodes the ID and presents the request on the matching target port. Several data-port IDs are folded onto one port, and the original ID travels with the request so the port can tell them apart.

A thread whose request is accepted by a real function goes to sleep and issues nothing more until a response carrying its thread tag comes back. When that response arrives, the router wakes the thread. It returns the data on a single writeback channel together with the destination register that it saved when the request was accepted.

IDs that name no function (the null ID and the reserved IDs) never reach a port. They complete at once with an error writeback, and the thread stays awake. When several threads aim at one target in the same cycle, a round-robin arbiter for that target picks one. The others wait under valid/ready backpressure.

Top module: `msg_router`

## Requirements
- R1: Target decode: ID 0x2 drives tgtValid bit 0, 0x3 bit 1, 0x5 bit 3, 0x6 bit 4, 0x7 bit 5, 0x8 bit 6, 0x9 bit 7, 0xB bit 8 and 0xD bit 9. Exactly one bit is raised for such a request, in the same cycle it is offered.
- R2: IDs 0x4, 0xA and 0xC all drive tgtValid bit 2, the shared data-port target. The 4-bit tgtFid field of that target carries the original ID unchanged.
- R3: A request with ID 0x0, 0x1, 0xE or 0xF raises no tgtValid bit and is accepted (reqReady high) in the cycle it is offered. One cycle later the writeback channel shows wbValid=1, wbErr=1 and wbData=0, with wbTid and wbDst set to the requester and its destination index. The thread's sleepMask bit stays 0.
- R4: For a target with tgtValid high, its tgtOp, tgtPay and tgtTid fields equal the op code, payload and thread index of the thread that target grants.
- R5: A request accepted by a real target sets the thread's sleepMask bit from the next cycle. While that bit is set, the thread's reqReady stays 0 and its further requests raise no tgtValid bit.
- R6: A response (rspValid=1) whose rspTid names a sleeping thread clears that sleepMask bit on the next cycle. In that same cycle it gives wbValid=1, wbErr=0, wbTid=rspTid, wbData=rspData and wbDst equal to the destination index saved at acceptance.
- R7: A response whose rspTid names a thread that is not sleeping has no effect: wbValid stays 0 and sleepMask is unchanged.
- R8: When a target's tgtReady is 0, its tgtValid still rises. The requesting thread sees reqReady=0, and its sleepMask bit stays 0 until a cycle in which tgtReady is 1.
- R9: Several threads contending for one target are served round-robin. The grant goes to the first requesting thread after the last thread that target served, in rising index order with wrap-around. After reset, the last served thread of every target counts as the highest index, so thread 0 comes first.
- R10: A response has priority over an error completion. In a cycle with rspValid=1, a null or reserved request sees reqReady=0 and is completed in a later cycle without a response.
- R11: After reset, sleepMask is all zero, wbValid is 0 and no tgtValid bit is raised while no request is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | THREADS | Per-thread request valid |
| reqReady | output | THREADS | Per-thread request accepted this cycle |
| reqFid | input | THREADS*4 | Per-thread function ID |
| reqOp | input | THREADS*OP_W | Per-thread function-specific op code |
| reqPay | input | THREADS*PAY_W | Per-thread operand payload |
| reqDst | input | THREADS*DST_W | Per-thread destination register index |
| tgtValid | output | 10 | Per-target request valid |
| tgtReady | input | 10 | Per-target ready |
| tgtFid | output | 40 | Original function ID per target |
| tgtOp | output | 10*OP_W | Op code per target |
| tgtPay | output | 10*PAY_W | Payload per target |
| tgtTid | output | 10*TW | Issuing thread index per target |
| rspValid | input | 1 | Response from a target |
| rspTid | input | TW | Thread tag of the response |
| rspData | input | RSP_W | Response data |
| wbValid | output | 1 | Writeback valid |
| wbErr | output | 1 | Writeback is an error completion |
| wbTid | output | TW | Writeback thread |
| wbDst | output | DST_W | Writeback destination register index |
| wbData | output | RSP_W | Writeback data |
| sleepMask | output | THREADS | Per-thread sleeping flag |

## Verification
The assertions assume that every request input is a known value and that rspTid names a thread that exists. They do not assume that responses only return to sleeping threads, because R7 defines what happens otherwise. The stimulus changes inputs only at the falling edge and holds each request until the cycle it is accepted. It deliberately sends one stray response to an awake thread. The sweep runs every one of the 16 IDs from every thread. The contention, backpressure and priority cases are then driven on their own, with the expected round-robin order tracked by a per-target last-served model in the bench.

// File: rtl/msg_router_pkg.sv
package msg_router_pkg;
  localparam int FID_W     = 4;
  localparam int NUM_TGT   = 10;
  localparam int THR_MAX   = 16;
  localparam int TID_MAX_W = 4;

  typedef struct packed {
    logic                 isErr;
    logic [3:0]           tgt;
  } route_t;

  typedef struct packed {
    logic [THR_MAX-1:0]   capture;
    logic                 rspLoad;
    logic [TID_MAX_W-1:0] rspTid;
    logic                 errLoad;
    logic [TID_MAX_W-1:0] errTid;
  } wb_strobe_t;

  function automatic route_t decodeFid(input logic [FID_W-1:0] fid);
    route_t r;
    r.isErr = 1'b0;
    r.tgt   = 4'd0;
    case (fid)
      4'h2: r.tgt = 4'd0;
      4'h3: r.tgt = 4'd1;
      4'h4, 4'hA, 4'hC: r.tgt = 4'd2;
      4'h5: r.tgt = 4'd3;
      4'h6: r.tgt = 4'd4;
      4'h7: r.tgt = 4'd5;
      4'h8: r.tgt = 4'd6;
      4'h9: r.tgt = 4'd7;
      4'hB: r.tgt = 4'd8;
      4'hD: r.tgt = 4'd9;
      default: r.isErr = 1'b1;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/msg_router_rr.sv
module msg_router_rr #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] req,
  input  logic         advance,
  output logic [N-1:0] grant
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] last;
  logic [IW-1:0] pick;
  int            idx;

  always_comb begin
    grant = '0;
    pick  = last;
    idx   = 0;
    for (int k = 1; k <= N; k++) begin
      idx = (int'(last) + k) % N;
      if (grant == '0 && req[idx]) begin
        grant[idx] = 1'b1;
        pick       = IW'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) last <= IW'(N - 1);
    else if (advance) last <= pick;
  end
endmodule

// File: rtl/msg_router_ctrl.sv
module msg_router_ctrl
  import msg_router_pkg::*;
#(
  parameter int THREADS = 4,
  localparam int TW = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [THREADS-1:0]          reqValid,
  input  logic [THREADS*FID_W-1:0]    reqFid,
  output logic [THREADS-1:0]          reqReady,
  output logic [NUM_TGT-1:0]          tgtValid,
  input  logic [NUM_TGT-1:0]          tgtReady,
  output logic [NUM_TGT*THREADS-1:0]  grantFlat,
  input  logic                        rspValid,
  input  logic [TW-1:0]               rspTid,
  output logic [THREADS-1:0]          sleepMask,
  output wb_strobe_t                  strb
);
  route_t                            route [THREADS];
  logic [NUM_TGT-1:0][THREADS-1:0]   elig;
  logic [NUM_TGT-1:0][THREADS-1:0]   grant;
  logic [NUM_TGT-1:0]                tgtFire;
  logic [THREADS-1:0]                errReq;
  logic [THREADS-1:0]                errGrant;
  logic                              errFire;
  logic [THREADS-1:0]                acceptReal;
  logic                              rspHit;
  logic [THREADS-1:0]                sleepNext;
  logic [TID_MAX_W-1:0]              errIdx;

  always_comb begin
    for (int th = 0; th < THREADS; th++) begin
      route[th] = decodeFid(reqFid[th*FID_W +: FID_W]);
    end
  end

  always_comb begin
    for (int t = 0; t < NUM_TGT; t++) begin
      for (int th = 0; th < THREADS; th++) begin
        elig[t][th] = reqValid[th] & ~sleepMask[th] & ~route[th].isErr &
                      (route[th].tgt == 4'(t));
      end
    end
    for (int th = 0; th < THREADS; th++) begin
      errReq[th] = reqValid[th] & ~sleepMask[th] & route[th].isErr;
    end
  end

  for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
    assign tgtValid[t] = |elig[t];
    assign tgtFire[t]  = tgtValid[t] & tgtReady[t];
    msg_router_rr #(.N(THREADS)) u_arb (
      .clk     (clk),
      .rstN    (rstN),
      .req     (elig[t]),
      .advance (tgtFire[t]),
      .grant   (grant[t])
    );
    assign grantFlat[t*THREADS +: THREADS] = grant[t];
  end

  assign errFire = (|errReq) & ~rspValid;

  msg_router_rr #(.N(THREADS)) u_errArb (
    .clk     (clk),
    .rstN    (rstN),
    .req     (errReq),
    .advance (errFire),
    .grant   (errGrant)
  );

  always_comb begin
    acceptReal = '0;
    for (int t = 0; t < NUM_TGT; t++) begin
      acceptReal = acceptReal | (grant[t] & {THREADS{tgtFire[t]}});
    end
    reqReady = acceptReal | (errGrant & {THREADS{errFire}});
    errIdx = '0;
    for (int th = 0; th < THREADS; th++) begin
      if (errGrant[th]) errIdx = TID_MAX_W'(th);
    end
  end

  assign rspHit = rspValid & sleepMask[rspTid];

  always_comb begin
    sleepNext = sleepMask;
    for (int th = 0; th < THREADS; th++) begin
      if (acceptReal[th]) sleepNext[th] = 1'b1;
      else if (rspHit && (int'(rspTid) == th)) sleepNext[th] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) sleepMask <= '0;
    else       sleepMask <= sleepNext;
  end

  always_comb begin
    strb = '0;
    strb.capture[THREADS-1:0] = acceptReal;
    strb.rspLoad = rspHit;
    strb.rspTid  = TID_MAX_W'(rspTid);
    strb.errLoad = errFire;
    strb.errTid  = errIdx;
  end

  for (genvar th = 0; th < THREADS; th++) begin : g_chk
    a_r5_sleep_set: assert property (@(posedge clk) disable iff (!rstN)
      acceptReal[th] |=> sleepMask[th]);
    a_r3_err_stays_awake: assert property (@(posedge clk) disable iff (!rstN)
      (errGrant[th] && errFire) |=> !sleepMask[th]);
    a_r5_no_ready_asleep: assert property (@(posedge clk) disable iff (!rstN)
      sleepMask[th] |-> !reqReady[th]);
  end
endmodule

// File: rtl/msg_router_dp.sv
module msg_router_dp
  import msg_router_pkg::*;
#(
  parameter int THREADS = 4,
  parameter int OP_W    = 8,
  parameter int PAY_W   = 16,
  parameter int DST_W   = 7,
  parameter int RSP_W   = 16,
  localparam int TW = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [THREADS*FID_W-1:0]    reqFid,
  input  logic [THREADS*OP_W-1:0]     reqOp,
  input  logic [THREADS*PAY_W-1:0]    reqPay,
  input  logic [THREADS*DST_W-1:0]    reqDst,
  input  logic [NUM_TGT*THREADS-1:0]  grantFlat,
  input  wb_strobe_t                  strb,
  input  logic                        rspValid,
  input  logic [RSP_W-1:0]            rspData,
  output logic [NUM_TGT*FID_W-1:0]    tgtFid,
  output logic [NUM_TGT*OP_W-1:0]     tgtOp,
  output logic [NUM_TGT*PAY_W-1:0]    tgtPay,
  output logic [NUM_TGT*TW-1:0]       tgtTid,
  output logic                        wbValid,
  output logic                        wbErr,
  output logic [TW-1:0]               wbTid,
  output logic [DST_W-1:0]            wbDst,
  output logic [RSP_W-1:0]            wbData
);
  logic [DST_W-1:0] dstMem [THREADS];
  logic [TW-1:0]    rspT;
  logic [TW-1:0]    errT;
  logic             unusedStrb;

  assign rspT = strb.rspTid[TW-1:0];
  assign errT = strb.errTid[TW-1:0];
  assign unusedStrb = ^{strb.capture, strb.rspTid, strb.errTid};

  always_comb begin
    tgtFid = '0;
    tgtOp  = '0;
    tgtPay = '0;
    tgtTid = '0;
    for (int t = 0; t < NUM_TGT; t++) begin
      for (int th = 0; th < THREADS; th++) begin
        if (grantFlat[t*THREADS + th]) begin
          tgtFid[t*FID_W +: FID_W] = tgtFid[t*FID_W +: FID_W] | reqFid[th*FID_W +: FID_W];
          tgtOp[t*OP_W +: OP_W]    = tgtOp[t*OP_W +: OP_W]    | reqOp[th*OP_W +: OP_W];
          tgtPay[t*PAY_W +: PAY_W] = tgtPay[t*PAY_W +: PAY_W] | reqPay[th*PAY_W +: PAY_W];
          tgtTid[t*TW +: TW]       = tgtTid[t*TW +: TW]       | TW'(th);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int th = 0; th < THREADS; th++) begin
      if (!rstN) dstMem[th] <= '0;
      else if (strb.capture[th]) dstMem[th] <= reqDst[th*DST_W +: DST_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wbValid <= 1'b0;
      wbErr   <= 1'b0;
      wbTid   <= '0;
      wbDst   <= '0;
      wbData  <= '0;
    end else begin
      wbValid <= strb.rspLoad | strb.errLoad;
      if (strb.rspLoad) begin
        wbErr  <= 1'b0;
        wbTid  <= rspT;
        wbDst  <= dstMem[rspT];
        wbData <= rspData;
      end else if (strb.errLoad) begin
        wbErr  <= 1'b1;
        wbTid  <= errT;
        wbDst  <= reqDst[int'(errT)*DST_W +: DST_W];
        wbData <= '0;
      end
    end
  end

  a_r6_wb_follows_rsp: assert property (@(posedge clk) disable iff (!rstN)
    (wbValid && !wbErr) |-> $past(rspValid));
  a_r10_err_not_with_rsp: assert property (@(posedge clk) disable iff (!rstN)
    (wbValid && wbErr) |-> !$past(rspValid));
  a_r3_err_data_zero: assert property (@(posedge clk) disable iff (!rstN)
    (wbValid && wbErr) |-> (wbData == '0));
endmodule

// File: rtl/msg_router.sv
module msg_router
  import msg_router_pkg::*;
#(
  parameter int THREADS = 4,
  parameter int OP_W    = 8,
  parameter int PAY_W   = 16,
  parameter int DST_W   = 7,
  parameter int RSP_W   = 16,
  localparam int TW = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [THREADS-1:0]         reqValid,
  output logic [THREADS-1:0]         reqReady,
  input  logic [THREADS*FID_W-1:0]   reqFid,
  input  logic [THREADS*OP_W-1:0]    reqOp,
  input  logic [THREADS*PAY_W-1:0]   reqPay,
  input  logic [THREADS*DST_W-1:0]   reqDst,
  output logic [NUM_TGT-1:0]         tgtValid,
  input  logic [NUM_TGT-1:0]         tgtReady,
  output logic [NUM_TGT*FID_W-1:0]   tgtFid,
  output logic [NUM_TGT*OP_W-1:0]    tgtOp,
  output logic [NUM_TGT*PAY_W-1:0]   tgtPay,
  output logic [NUM_TGT*TW-1:0]      tgtTid,
  input  logic                       rspValid,
  input  logic [TW-1:0]              rspTid,
  input  logic [RSP_W-1:0]           rspData,
  output logic                       wbValid,
  output logic                       wbErr,
  output logic [TW-1:0]              wbTid,
  output logic [DST_W-1:0]           wbDst,
  output logic [RSP_W-1:0]           wbData,
  output logic [THREADS-1:0]         sleepMask
);
  logic [NUM_TGT*THREADS-1:0] grantFlat;
  wb_strobe_t                 strb;

  msg_router_ctrl #(.THREADS(THREADS)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqFid    (reqFid),
    .reqReady  (reqReady),
    .tgtValid  (tgtValid),
    .tgtReady  (tgtReady),
    .grantFlat (grantFlat),
    .rspValid  (rspValid),
    .rspTid    (rspTid),
    .sleepMask (sleepMask),
    .strb      (strb)
  );

  msg_router_dp #(
    .THREADS (THREADS),
    .OP_W    (OP_W),
    .PAY_W   (PAY_W),
    .DST_W   (DST_W),
    .RSP_W   (RSP_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .reqFid    (reqFid),
    .reqOp     (reqOp),
    .reqPay    (reqPay),
    .reqDst    (reqDst),
    .grantFlat (grantFlat),
    .strb      (strb),
    .rspValid  (rspValid),
    .rspData   (rspData),
    .tgtFid    (tgtFid),
    .tgtOp     (tgtOp),
    .tgtPay    (tgtPay),
    .tgtTid    (tgtTid),
    .wbValid   (wbValid),
    .wbErr     (wbErr),
    .wbTid     (wbTid),
    .wbDst     (wbDst),
    .wbData    (wbData)
  );
endmodule

// File: tb/msg_router_bench.sv
module msg_router_bench;
  localparam int CLK_PERIOD = 10;
  localparam int T   = 4;
  localparam int TW  = 2;
  localparam int NT  = 10;
  localparam int OPW = 8;
  localparam int PW  = 16;
  localparam int DW  = 7;
  localparam int RW  = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [T-1:0]    reqValid = '0;
  logic [T-1:0]    reqReady;
  logic [T*4-1:0]  reqFid = '0;
  logic [T*OPW-1:0] reqOp = '0;
  logic [T*PW-1:0] reqPay = '0;
  logic [T*DW-1:0] reqDst = '0;
  logic [NT-1:0]   tgtValid;
  logic [NT-1:0]   tgtReady = '1;
  logic [NT*4-1:0] tgtFid;
  logic [NT*OPW-1:0] tgtOp;
  logic [NT*PW-1:0] tgtPay;
  logic [NT*TW-1:0] tgtTid;
  logic            rspValid = 1'b0;
  logic [TW-1:0]   rspTid = '0;
  logic [RW-1:0]   rspData = '0;
  logic            wbValid, wbErr;
  logic [TW-1:0]   wbTid;
  logic [DW-1:0]   wbDst;
  logic [RW-1:0]   wbData;
  logic [T-1:0]    sleepMask;

  int nChk = 0;
  int nFail = 0;
  int lastServed [NT];
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  msg_router u_msg_router (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqFid(reqFid), .reqOp(reqOp), .reqPay(reqPay), .reqDst(reqDst),
    .tgtValid(tgtValid), .tgtReady(tgtReady), .tgtFid(tgtFid), .tgtOp(tgtOp),
    .tgtPay(tgtPay), .tgtTid(tgtTid), .rspValid(rspValid), .rspTid(rspTid),
    .rspData(rspData), .wbValid(wbValid), .wbErr(wbErr), .wbTid(wbTid),
    .wbDst(wbDst), .wbData(wbData), .sleepMask(sleepMask)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic int expTgt(input int id);
    case (id)
      2: return 0;
      3: return 1;
      4, 10, 12: return 2;
      5: return 3;
      6: return 4;
      7: return 5;
      8: return 6;
      9: return 7;
      11: return 8;
      13: return 9;
      default: return -1;
    endcase
  endfunction

  task automatic offer(input int th, input int id, input int dst);
    reqValid[th] = 1'b1;
    reqFid[th*4 +: 4] = 4'(id);
    reqOp[th*OPW +: OPW] = 8'(id*16 + th);
    reqPay[th*PW +: PW] = 16'(id*257 + th*3);
    reqDst[th*DW +: DW] = 7'(dst);
  endtask

  task automatic respond(input int th, input int data, input int dst);
    @(negedge clk);
    rspValid = 1'b1; rspTid = 2'(th); rspData = 16'(data);
    @(posedge clk); #1;
    chk("R6 wbValid", 32'(wbValid), 32'd1);
    chk("R6 wbErr", 32'(wbErr), 32'd0);
    chk("R6 wbTid", 32'(wbTid), 32'(th));
    chk("R6 wbDst", 32'(wbDst), 32'(dst));
    chk("R6 wbData", 32'(wbData), 32'(data & 16'hFFFF));
    chk("R6 sleep cleared", 32'(sleepMask[th]), 32'd0);
    @(negedge clk);
    rspValid = 1'b0;
  endtask

  initial begin
    for (int t = 0; t < NT; t++) lastServed[t] = T - 1;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1;
    chk("R11 sleepMask", 32'(sleepMask), 32'd0);
    chk("R11 wbValid", 32'(wbValid), 32'd0);
    chk("R11 tgtValid", 32'(tgtValid), 32'd0);

    // Sweep every ID from every thread
    for (int th = 0; th < T; th++) begin
      for (int id = 0; id < 16; id++) begin
        int e;
        int dst;
        e = expTgt(id);
        dst = id + 16*th;
        @(negedge clk);
        offer(th, id, dst);
        #1;
        if (e < 0) begin
          chk("R3 no target", 32'(tgtValid), 32'd0);
          chk("R3 ready", 32'(reqReady[th]), 32'd1);
          @(posedge clk); #1;
          chk("R3 wbValid", 32'(wbValid), 32'd1);
          chk("R3 wbErr", 32'(wbErr), 32'd1);
          chk("R3 wbData", 32'(wbData), 32'd0);
          chk("R3 wbTid", 32'(wbTid), 32'(th));
          chk("R3 wbDst", 32'(wbDst), 32'(dst));
          chk("R3 awake", 32'(sleepMask), 32'd0);
          @(negedge clk); reqValid = '0;
        end else begin
          chk("R1 tgtValid", 32'(tgtValid), 32'(1 << e));
          chk(e == 2 ? "R2 tgtFid" : "R1 tgtFid", 32'(tgtFid[e*4 +: 4]), 32'(id));
          chk("R4 tgtOp", 32'(tgtOp[e*OPW +: OPW]), 32'((id*16 + th) & 8'hFF));
          chk("R4 tgtPay", 32'(tgtPay[e*PW +: PW]), 32'(id*257 + th*3));
          chk("R4 tgtTid", 32'(tgtTid[e*TW +: TW]), 32'(th));
          chk("R1 ready", 32'(reqReady[th]), 32'd1);
          lastServed[e] = th;
          @(posedge clk); #1;
          chk("R5 sleep set", 32'(sleepMask), 32'(1 << th));
          @(negedge clk); #1;
          chk("R5 ready low asleep", 32'(reqReady[th]), 32'd0);
          chk("R5 no valid asleep", 32'(tgtValid), 32'd0);
          reqValid = '0;
          respond(th, 16'hA000 + id*16 + th, dst);
        end
      end
    end

    // R7: stray response to an awake thread
    @(negedge clk);
    rspValid = 1'b1; rspTid = 2'd1; rspData = 16'h1234;
    @(posedge clk); #1;
    chk("R7 no wb", 32'(wbValid), 32'd0);
    chk("R7 sleep unchanged", 32'(sleepMask), 32'd0);
    @(negedge clk); rspValid = 1'b0;

    // R8: backpressure
    tgtReady = '0;
    offer(2, 8, 55);
    #1;
    chk("R8 tgtValid", 32'(tgtValid[6]), 32'd1);
    chk("R8 ready low", 32'(reqReady[2]), 32'd0);
    @(posedge clk); #1;
    chk("R8 no sleep", 32'(sleepMask), 32'd0);
    @(negedge clk); tgtReady = '1; #1;
    chk("R8 ready after release", 32'(reqReady[2]), 32'd1);
    lastServed[6] = 2;
    @(posedge clk); #1;
    chk("R8 sleep after release", 32'(sleepMask), 32'b0100);
    @(negedge clk); reqValid = '0;
    respond(2, 16'h5A5A, 55);

    // R9: all threads contend for the sampler
    @(negedge clk);
    for (int th = 0; th < T; th++) offer(th, 2, 40 + th);
    begin
      bit [T-1:0] pend;
      pend = '1;
      for (int n = 0; n < T; n++) begin
        int expT;
        expT = -1;
        for (int k = 1; k <= T; k++) begin
          int c;
          c = (lastServed[0] + k) % T;
          if (expT < 0 && pend[c]) expT = c;
        end
        #1;
        chk("R9 rr grant", 32'(tgtTid[0 +: TW]), 32'(expT));
        chk("R9 single ready", 32'(reqReady), 32'(1 << expT));
        lastServed[0] = expT;
        pend[expT] = 1'b0;
        @(posedge clk);
        @(negedge clk);
      end
    end
    chk("R9 all asleep", 32'(sleepMask), 32'hF);
    reqValid = '0;
    for (int th = 0; th < T; th++) respond(th, 16'h0B00 + th, 40 + th);

    // R10: response beats an error completion
    @(negedge clk);
    offer(1, 3, 9);
    @(posedge clk);
    @(negedge clk);
    reqValid = '0;
    offer(0, 15, 21);
    rspValid = 1'b1; rspTid = 2'd1; rspData = 16'h7777;
    #1;
    chk("R10 err waits", 32'(reqReady[0]), 32'd0);
    @(posedge clk); #1;
    chk("R10 rsp first", 32'(wbErr), 32'd0);
    chk("R10 rsp tid", 32'(wbTid), 32'd1);
    @(negedge clk);
    rspValid = 1'b0;
    #1;
    chk("R10 err accepted later", 32'(reqReady[0]), 32'd1);
    @(posedge clk); #1;
    chk("R10 err wb", 32'(wbErr), 32'd1);
    chk("R3 err tid", 32'(wbTid), 32'd0);
    @(negedge clk); reqValid = '0;

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  end
endmodule